// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is a 32-pin general-purpose I/O port reached through a plain single-cycle register bus made of an address, a write strobe, write data and combinational read data. Each pin is either driven from an output register or sampled as an input through a two-flop synchronizer. Any input pin can also act as an interrupt source. A 2-bit field per pin selects the sense, and the fields for the low sixteen pins and the high sixteen pins sit in two adjacent configuration words.

Detected events are latched in a status register that software clears by writing ones. A single interrupt line is raised whenever a latched status bit has its mask bit set. Level sources re-assert their status bit as long as the condition holds, so a clear only takes effect once the level has gone away. Edge sources stay latched until they are cleared, whether or not they are masked.

Word map (byte addresses): 0x00 pin data, 0x04 direction, 0x08 sense for pins 0..15, 0x0C sense for pins 16..31, 0x10 mask, 0x14 status. Unmapped addresses read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, direction, mask, status and output data read back as zero, `pad_oe` is zero and `irq` is low.
- R2: A direction bit of 1 makes the pin an output: `pad_oe` follows the direction register and `pad_out` follows the data register. Reading 0x00 returns the output register bit for output pins and the synchronized input for input pins.
- R3: The sense field for pin n is at bits [2*(n mod 16)+1 : 2*(n mod 16)] of word 0x08 when n < 16, and of word 0x0C otherwise. The encoding is 00 low level, 01 high level, 10 rising edge, 11 falling edge. Both words read back what was written.
- R4: An input pin with rising-edge sense sets its status bit when the synchronized input goes from 0 to 1, and the bit stays set until it is cleared.
- R5: An input pin with falling-edge sense sets its status bit only on a 1-to-0 transition and does not set it on a 0-to-1 transition.
- R6: An input pin with level sense keeps its status bit set while the level is active, so a clear written during the level leaves the bit set. Once the level is gone, a clear takes effect.
- R7: Writing to 0x14 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R8: `irq` is high exactly when some status bit and its mask bit are both 1. A masked edge event is still latched in status.
- R9: When a new event arrives on a pin in the same cycle that a clear write to that pin's status bit is sampled, the status bit stays set.
- R10: A pin configured as an output never sets its status bit, whatever its pad level.
- R11: A change on `pad_in` becomes visible in a read of 0x00 after two rising clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Byte address of the register word |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output values to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
Each of the four senses is applied to its own pin with both pad polarities, so that a level source can be told apart from an edge source and a rising edge from a falling edge. A rising pulse is placed so that its event lines up with a clear write, which separates an event-wins design from a clear-wins one. A clear is also issued while a high level persists and again after it drops, which tells re-assertion apart from a bit that was simply never cleared. A pin is toggled while it is an output to show that output pins raise no events, and a single step on an input is read after one and after two edges to measure the synchronizer depth.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   pad_in,
  output logic [31:0]   pad_out,
  output logic [31:0]   pad_oe,
  output logic          irq
);
  localparam int NP   = 32;
  localparam int HALF = NP / 2;
  localparam logic [2:0] W_DATA = 3'd0, W_DIR = 3'd1, W_SLO = 3'd2,
                         W_SHI = 3'd3, W_MASK = 3'd4, W_STAT = 3'd5;

  logic [NP-1:0] out_q, dir_q, mask_q, stat_q;
  logic [31:0]   slo_q, shi_q;
  logic [NP-1:0] sy1, sy2, sy3;
  logic [NP-1:0] ev, clr;
  logic [2:0]    widx;
  logic          in_range;

  assign widx     = reg_addr[4:2];
  assign in_range = (reg_addr >> 5) == '0;
  assign clr      = (reg_we && in_range && widx == W_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      slo_q  <= '0;
      shi_q  <= '0;
      mask_q <= '0;
    end else if (reg_we && in_range) begin
      case (widx)
        W_DATA: out_q  <= reg_wdata;
        W_DIR:  dir_q  <= reg_wdata;
        W_SLO:  slo_q  <= reg_wdata;
        W_SHI:  shi_q  <= reg_wdata;
        W_MASK: mask_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= pad_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  for (genvar n = 0; n < NP; n++) begin : g_pin
    logic [1:0] sns;
    logic       hit;
    if (n < HALF) begin : g_lo
      assign sns = slo_q[2*n +: 2];
    end else begin : g_hi
      assign sns = shi_q[2*(n-HALF) +: 2];
    end
    always_comb begin
      case (sns)
        2'b00:   hit = ~sy2[n];
        2'b01:   hit = sy2[n];
        2'b10:   hit = sy2[n] & ~sy3[n];
        default: hit = ~sy2[n] & sy3[n];
      endcase
    end
    assign ev[n] = hit & ~dir_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | ev;
  end

  always_comb begin
    reg_rdata = '0;
    if (in_range) begin
      case (widx)
        W_DATA: reg_rdata = (dir_q & out_q) | (~dir_q & sy2);
        W_DIR:  reg_rdata = dir_q;
        W_SLO:  reg_rdata = slo_q;
        W_SHI:  reg_rdata = shi_q;
        W_MASK: reg_rdata = mask_q;
        W_STAT: reg_rdata = stat_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);

  p_oe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_range && widx == W_DIR) |=> pad_oe == $past(reg_wdata));

  p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr)) & ~stat_q) == '0));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr && ev == '0) |=> ((stat_q & $past(clr)) == '0));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && stat_q != '0));

  p_output_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_q & ~$past(stat_q)) & $past(dir_q)) == '0));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_SLO = 5'h08,
                         A_SHI = 5'h0C, A_MASK = 5'h10, A_STAT = 5'h14;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0, rst_n = 0, reg_we = 0, smp = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq;
  item_t       q[$];
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  gpio_irq_port #(.AW(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic expect_k(int kind, logic [4:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    #1 smp = 1;
    #1 smp = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] e, string tag);
    expect_k(0, a, e, tag);
  endtask

  always @(posedge smp) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    case (it.kind)
      0: act = reg_rdata;
      1: act = {31'b0, irq};
      2: act = pad_out;
      default: act = pad_oe;
    endcase
    n_chk++;
    if (act !== it.exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
    end
  end

  initial begin
    // R1: reset state
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_DIR, 32'h0, "R1 dir");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_DATA, 32'h0, "R1 data");
    expect_k(1, A_DATA, 32'h0, "R1 irq");
    expect_k(3, A_DATA, 32'h0, "R1 pad_oe");
    @(negedge clk); rst_n = 1;
    wr(A_SLO, 32'hAAAAAAAA);
    wr(A_SHI, 32'hAAAAAAAA);
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT, 32'h0, "R7 clear all");
    rd(A_SLO, 32'hAAAAAAAA, "R3 sense lo readback");

    // R4 rising edge, R8 masking
    pad_in[3] = 1; idle(4);
    rd(A_STAT, 32'h8, "R4 rise latched");
    expect_k(1, A_DATA, 32'h0, "R8 masked irq low");
    wr(A_MASK, 32'h8);
    expect_k(1, A_DATA, 32'h1, "R8 irq high");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h8, "R7 zero write keeps");
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h0, "R7 one write clears");
    expect_k(1, A_DATA, 32'h0, "R8 irq after clear");

    // R9 event vs clear in the same cycle
    pad_in[3] = 0; idle(4);
    pad_in[3] = 1; idle(4);
    rd(A_STAT, 32'h8, "R4 second rise");
    pad_in[3] = 0; idle(4);
    rd(A_STAT, 32'h8, "R4 held over fall");
    @(negedge clk); pad_in[3] = 1;
    @(negedge clk);
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h8, "R9 event wins");
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h0, "R9 later clear");

    // R3/R5 falling edge on pin 20 (hi word bits 9:8 = 11)
    // R6 high level on pin 17 (hi word bits 3:2 = 01)
    wr(A_SHI, 32'hAAAAABA6);
    rd(A_SHI, 32'hAAAAABA6, "R3 sense hi readback");
    pad_in[20] = 1; idle(4);
    rd(A_STAT, 32'h0, "R5 no event on rise");
    pad_in[20] = 0; idle(4);
    rd(A_STAT, 32'h0010_0000, "R5 fall latched");
    wr(A_STAT, 32'h0010_0000);
    pad_in[17] = 1; idle(4);
    rd(A_STAT, 32'h0002_0000, "R6 high level");
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, 32'h0002_0000, "R6 re-set while high");
    pad_in[17] = 0; idle(4);
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, 32'h0, "R6 clear after level gone");

    // R6 low level on pin 1 (lo word bits 3:2 = 00)
    wr(A_SLO, 32'hAAAAAAA2);
    idle(2);
    rd(A_STAT, 32'h2, "R6 low level");
    pad_in[1] = 1; idle(4);
    wr(A_STAT, 32'h2);
    rd(A_STAT, 32'h0, "R6 low level cleared");

    // R2 output pins, R10 no events from outputs
    wr(A_DATA, 32'h20);
    wr(A_DIR, 32'h20);
    expect_k(3, A_DATA, 32'h20, "R2 pad_oe");
    expect_k(2, A_DATA, 32'h20, "R2 pad_out");
    pad_in[5] = 0; idle(4);
    rd(A_DATA, (32'h20 & 32'h20) | (~32'h20 & pad_in), "R2 data mix");
    pad_in[5] = 1; idle(4);
    pad_in[5] = 0; idle(4);
    rd(A_STAT, 32'h0, "R10 output quiet");

    // R11 two-stage input synchronizer on pin 9 (rising sense)
    @(negedge clk); pad_in[9] = 1;
    rd(A_DATA, 32'h20 | (pad_in & ~32'h20 & ~32'h200), "R11 after one edge");
    rd(A_DATA, 32'h20 | (pad_in & ~32'h20), "R11 after two edges");
    idle(2);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule